// File: doc/BRIEF.md
# Bus Back-Off Cycle Restart Controller

This block sits between a processor core and a shared system bus. It takes one cycle at a time from the core, either a four-beat burst or a single transfer, and runs it on the bus. Each cycle has one address-strobe clock followed by data beats, and each beat is closed by a ready from the bus. A separate input from the snoop unit asks for a modified-line writeback. The controller runs that writeback as a four-beat burst write, and it always has priority.

Another bus master can push the controller off the bus with a back-off input, at any point and for any length of time. The controller then drops the cycle in progress and floats its bus outputs. It keeps requesting the bus while work is outstanding. When back-off goes away, it starts the dropped cycle again from its first beat, with no dead clock in between. If a writeback became pending in the meantime, the writeback goes first.

Locked sequences are tracked with a lock output. The lock stays high through any back-off window and through the replay. Cycles of a locked sequence that had already completed are never run again.

Top module: `bko_seq`

## Requirements
- R1: While reset is high and in the first clock after it, the address strobe, float, bus request and lock outputs are low, and the core request port reports ready.
- R2: A core cycle shows the address strobe for exactly one clock, carrying the request's address, write flag and burst flag. It then needs four accepted readies if burst=1, or one if burst=0. The core completion pulse is high in the clock of the final accepted ready and never earlier.
- R3: When back-off is sampled high at a clock edge, the float output is high and the address strobe is low from the next clock on. This holds for as many clocks as back-off stays high, plus the clock in which back-off is first seen low.
- R4: A ready sampled in the same clock as back-off is not counted as a beat and produces no completion pulse.
- R5: Bus request is high in every clock in which a core cycle is outstanding (including an aborted one), a writeback is pending, or a new request is offered. It is low when none of these holds.
- R6: In the clock right after back-off is sampled low, with no writeback pending, the aborted cycle's address strobe appears with the same address. The cycle again needs its full beat count. This applies whether the abort came in the address clock or in a data clock.
- R7: If a writeback is pending when back-off is released, the next address strobe is a burst write at the writeback address. The writeback completion pulse comes on its fourth accepted ready. The aborted core cycle starts only after one idle clock. The snoop unit drops its pending flag in the clock after that pulse.
- R8: After any cycle completes, the next clock has no address strobe.
- R9: The lock output rises with the address strobe of a cycle marked locked. It stays high through back-off and replay until the completion of the cycle marked as the end of the lock, and is low in the clock after that. Only the unfinished locked cycle is replayed after release.
- R10: The core request port reports ready only when the controller is idle or backed off, back-off is low, no writeback is pending and no core cycle is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core offers a cycle |
| req_addr | input | AW | Cycle address |
| req_write | input | 1 | 1 = write cycle |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single transfer |
| req_lock | input | 1 | Cycle belongs to a locked sequence |
| req_lock_end | input | 1 | Cycle is the last of the locked sequence |
| req_ready | output | 1 | Cycle accepted at this edge when valid |
| core_done | output | 1 | Core cycle completes this clock |
| wb_pend | input | 1 | Snoop writeback waiting |
| wb_addr | input | AW | Writeback address |
| wb_done | output | 1 | Writeback completes this clock |
| bus_ads | output | 1 | Address strobe, active high |
| bus_addr | output | AW | Bus address |
| bus_write | output | 1 | Bus write flag |
| bus_burst | output | 1 | Bus burst flag |
| bus_lock | output | 1 | Locked sequence in progress |
| bus_rdy | input | 1 | Beat ready from the bus |
| bus_boff | input | 1 | Back-off from another master |
| bus_req | output | 1 | Bus request |
| bus_float | output | 1 | Outputs released while backed off |

## Verification
The hardest situation to reach is a back-off that arrives in exactly the clock where a ready would have closed the final beat, while a writeback becomes pending before release. The beat is lost, the writeback goes first, and the whole cycle runs again. The bench reaches this by sweeping the abort point over every clock of a cycle: the address clock, each data beat and the final beat. It combines each abort point with back-off lengths from one to three clocks and with a writeback pending or not at release. A locked two-cycle sequence whose second cycle is aborted covers lock retention and the rule that completed cycles are not replayed.

// File: rtl/bko_pkg.sv
package bko_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_BOFF
    } bus_st_e;

    // beats a cycle needs for a given burst flag
    function automatic int unsigned beats_of(input logic burst, input int unsigned blen);
        return burst ? blen : 1;
    endfunction

endpackage

// File: rtl/bko_beat_ctr.sv
module bko_beat_ctr
    import bko_pkg::*;
#(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_data,
    input  logic take,
    input  logic burst,
    output logic final_beat
);
    localparam int unsigned CW = $clog2(BEATS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] need;

    assign need       = CW'(beats_of(burst, BEATS));
    assign final_beat = take && (cnt == need - CW'(1));

    // count is zero outside data clocks, so an abort restarts the cycle at beat 0
    always_ff @(posedge clk) begin
        if (rst || !in_data)
            cnt <= '0;
        else if (take)
            cnt <= final_beat ? '0 : cnt + CW'(1);
    end

    a_r2_beat_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < need);

    a_r6_restart_zero: assert property (@(posedge clk) disable iff (rst)
        !in_data |=> (cnt == '0));

endmodule

// File: rtl/bko_lock_trk.sv
module bko_lock_trk (
    input  logic clk,
    input  logic rst,
    input  logic start_locked,
    input  logic end_locked,
    output logic lock_o
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else if (end_locked)
            lock_q <= 1'b0;
        else if (start_locked)
            lock_q <= 1'b1;
    end

    assign lock_o = lock_q || start_locked;

    a_r9_lock_drop: assert property (@(posedge clk) disable iff (rst)
        end_locked |=> !lock_o || start_locked);

endmodule

// File: rtl/bko_seq.sv
module bko_seq
    import bko_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic          req_lock,
    input  logic          req_lock_end,
    output logic          req_ready,
    output logic          core_done,
    input  logic          wb_pend,
    input  logic [AW-1:0] wb_addr,
    output logic          wb_done,
    output logic          bus_ads,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic          bus_burst,
    output logic          bus_lock,
    input  logic          bus_rdy,
    input  logic          bus_boff,
    output logic          bus_req,
    output logic          bus_float
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          write;
        logic          burst;
        logic          lock;
        logic          lock_end;
    } cyc_t;

    bus_st_e state;
    cyc_t    cur;
    logic    cur_valid;
    logic    on_wb;

    logic    can_launch;
    logic    have_work;
    logic    take;
    logic    final_beat;
    logic    lock_start;
    logic    lock_end;

    assign have_work  = wb_pend || cur_valid || req_valid;
    assign can_launch = !bus_boff && (state == ST_IDLE || state == ST_BOFF);
    assign req_ready  = can_launch && !wb_pend && !cur_valid;

    assign take       = (state == ST_DATA) && bus_rdy && !bus_boff;
    assign core_done  = final_beat && !on_wb;
    assign wb_done    = final_beat && on_wb;

    assign bus_ads    = (state == ST_ADDR);
    assign bus_float  = (state == ST_BOFF);
    assign bus_req    = have_work;
    assign bus_addr   = on_wb ? wb_addr : cur.addr;
    assign bus_write  = on_wb ? 1'b1    : cur.write;
    assign bus_burst  = on_wb ? 1'b1    : cur.burst;

    assign lock_start = (state == ST_ADDR) && !on_wb && cur.lock;
    assign lock_end   = core_done && cur.lock_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cur_valid <= 1'b0;
            on_wb     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_BOFF: begin
                    if (bus_boff) begin
                        state <= ST_BOFF;
                    end else if (have_work) begin
                        state <= ST_ADDR;
                        on_wb <= wb_pend;
                        if (req_ready && req_valid) begin
                            cur       <= '{addr: req_addr, write: req_write, burst: req_burst,
                                           lock: req_lock, lock_end: req_lock_end};
                            cur_valid <= 1'b1;
                        end
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    state <= bus_boff ? ST_BOFF : ST_DATA;
                end
                ST_DATA: begin
                    if (bus_boff) begin
                        state <= ST_BOFF;
                    end else if (final_beat) begin
                        state <= ST_IDLE;
                        if (on_wb)
                            on_wb <= 1'b0;
                        else
                            cur_valid <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    bko_beat_ctr #(.BEATS(BURST_LEN)) u_beats (
        .clk        (clk),
        .rst        (rst),
        .in_data    (state == ST_DATA),
        .take       (take),
        .burst      (bus_burst),
        .final_beat (final_beat)
    );

    bko_lock_trk u_lock (
        .clk          (clk),
        .rst          (rst),
        .start_locked (lock_start),
        .end_locked   (lock_end),
        .lock_o       (bus_lock)
    );

    a_r3_float_next: assert property (@(posedge clk) disable iff (rst)
        bus_boff |=> bus_float && !bus_ads);

    a_r4_rdy_ignored: assert property (@(posedge clk) disable iff (rst)
        bus_boff |-> !core_done && !wb_done);

    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (bus_float && cur_valid) |-> bus_req);

    a_r6_replay_now: assert property (@(posedge clk) disable iff (rst)
        (bus_float && !bus_boff && cur_valid && !wb_pend) |=>
            (bus_ads && bus_addr == $past(cur.addr)));

    a_r7_wb_first: assert property (@(posedge clk) disable iff (rst)
        (bus_float && !bus_boff && wb_pend) |=>
            (bus_ads && bus_write && bus_burst && bus_addr == $past(wb_addr)));

    a_r8_dead_clock: assert property (@(posedge clk) disable iff (rst)
        (core_done || wb_done) |=> !bus_ads);

    a_r9_lock_kept: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && !lock_end) |=> bus_lock);

    a_r10_accept_gate: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_boff && !wb_pend && !bus_ads);

endmodule

// File: tb/test_bko_seq.sv
`timescale 1ns/1ps
module test_bko_seq;
    localparam int AW = 32;
    localparam logic [AW-1:0] WBA = 32'h0000_F000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_burst = 1'b0;
    logic          req_lock = 1'b0;
    logic          req_lock_end = 1'b0;
    logic          req_ready;
    logic          core_done;
    logic          wb_pend = 1'b0;
    logic [AW-1:0] wb_addr = WBA;
    logic          wb_done;
    logic          bus_ads;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic          bus_burst;
    logic          bus_lock;
    logic          bus_rdy = 1'b0;
    logic          bus_boff = 1'b0;
    logic          bus_req;
    logic          bus_float;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bko_seq #(.AW(AW), .BURST_LEN(4)) i_bko_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_burst(req_burst), .req_lock(req_lock), .req_lock_end(req_lock_end),
        .req_ready(req_ready), .core_done(core_done),
        .wb_pend(wb_pend), .wb_addr(wb_addr), .wb_done(wb_done),
        .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_burst(bus_burst), .bus_lock(bus_lock), .bus_rdy(bus_rdy),
        .bus_boff(bus_boff), .bus_req(bus_req), .bus_float(bus_float)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // step to just after the next rising edge; inputs are then changed here
    task automatic nx();
        @(posedge clk);
        #1;
    endtask

    // boff_at: -1 = abort in the address clock, 0..nb-1 = after that many beats, nb = no abort
    task automatic run_case(input bit burst, input bit wr, input int boff_at,
                            input int blen, input bit wbf, input logic [AW-1:0] a);
        int nb;
        nb = burst ? 4 : 1;
        nx();
        req_valid = 1'b1; req_addr = a; req_write = wr; req_burst = burst;
        req_lock = 1'b0; req_lock_end = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        chk(bus_req == 1'b1, "R5", "req with offer", bus_req, 1);
        nx();
        req_valid = 1'b0;
        #1;
        chk(bus_ads && bus_addr == a && bus_burst == burst && bus_write == wr,
            "R2", "first strobe addr", bus_addr, a);
        chk(req_ready == 1'b0, "R10", "busy not ready", req_ready, 0);
        if (boff_at < 0) bus_boff = 1'b1;
        if (boff_at >= 0) begin
            for (int i = 0; i < boff_at && i < nb; i++) begin
                nx(); bus_rdy = 1'b1; #1;
                chk(core_done == (i == nb - 1), "R2", "done only on last beat", core_done, i == nb - 1);
            end
            if (boff_at == nb) begin
                nx(); bus_rdy = 1'b0; #1;
                chk(!bus_ads && req_ready, "R8", "idle after done", bus_ads, 0);
                return;
            end
            nx(); bus_rdy = 1'b1; bus_boff = 1'b1; #1;
            chk(!core_done && !wb_done, "R4", "ready under back-off ignored", core_done, 0);
        end
        for (int j = 1; j < blen; j++) begin
            nx(); bus_rdy = 1'b0; bus_boff = 1'b1; #1;
            chk(bus_float && !bus_ads, "R3", "floated while held", bus_float, 1);
            chk(bus_req == 1'b1, "R5", "req held in back-off", bus_req, 1);
        end
        nx(); bus_rdy = 1'b0; bus_boff = 1'b0; wb_pend = wbf; #1;
        chk(bus_float && !bus_ads, "R3", "float in release clock", bus_float, 1);
        chk(req_ready == 1'b0, "R10", "outstanding not ready", req_ready, 0);
        nx(); #1;
        if (wbf) begin
            chk(bus_ads && bus_write && bus_burst && bus_addr == WBA,
                "R7", "writeback first", bus_addr, WBA);
            for (int i = 0; i < 4; i++) begin
                nx(); bus_rdy = 1'b1; #1;
                chk(wb_done == (i == 3) && !core_done, "R7", "wb done on 4th", wb_done, i == 3);
            end
            nx(); bus_rdy = 1'b0; wb_pend = 1'b0; #1;
            chk(!bus_ads, "R8", "dead clock after wb", bus_ads, 0);
            nx(); #1;
        end
        chk(bus_ads && bus_addr == a && bus_burst == burst, "R6", "replay strobe", bus_addr, a);
        for (int i = 0; i < nb; i++) begin
            nx(); bus_rdy = 1'b1; #1;
            chk(core_done == (i == nb - 1), "R6", "full beat count on replay", core_done, i == nb - 1);
        end
        nx(); bus_rdy = 1'b0; #1;
        chk(!bus_ads && req_ready && !bus_req, "R8", "idle after replay", bus_ads, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!bus_ads && !bus_float && !bus_req && !bus_lock, "R1", "outputs in reset", bus_ads, 0);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // back-off with nothing to do
        nx(); bus_boff = 1'b1; #1;
        nx(); bus_boff = 1'b0; #1;
        chk(bus_float && !bus_req, "R5", "idle back-off no request", bus_req, 0);
        nx(); #1;
        chk(!bus_float && !bus_ads, "R3", "release to idle", bus_float, 0);

        for (int b = 0; b < 2; b++)
            for (int k = -1; k <= (b != 0 ? 4 : 1); k++)
                for (int l = 1; l <= 3; l++)
                    for (int w = 0; w < 2; w++)
                        run_case(b[0], w[0] ^ l[0], k, l, w[0],
                                 32'h100 + 32'(b * 4096 + (k + 1) * 256 + l * 16 + w));

        // locked pair, second aborted
        nx(); req_valid = 1'b1; req_addr = 32'hA0; req_burst = 1'b0; req_write = 1'b0;
        req_lock = 1'b1; req_lock_end = 1'b0; #1;
        nx(); req_valid = 1'b0; #1;
        chk(bus_ads && bus_lock, "R9", "lock with strobe", bus_lock, 1);
        nx(); bus_rdy = 1'b1; #1;
        chk(core_done == 1'b1, "R9", "first locked done", core_done, 1);
        nx(); bus_rdy = 1'b0; req_valid = 1'b1; req_addr = 32'hB0; req_burst = 1'b1;
        req_lock = 1'b1; req_lock_end = 1'b1; #1;
        chk(bus_lock == 1'b1, "R9", "lock between cycles", bus_lock, 1);
        nx(); req_valid = 1'b0; #1;
        nx(); bus_rdy = 1'b1; #1;
        nx(); bus_rdy = 1'b1; bus_boff = 1'b1; #1;
        nx(); bus_rdy = 1'b0; #1;
        chk(bus_float && bus_lock, "R9", "lock held in back-off", bus_lock, 1);
        nx(); bus_boff = 1'b0; #1;
        nx(); #1;
        chk(bus_ads && bus_addr == 32'hB0, "R9", "only unfinished replayed", bus_addr, 32'hB0);
        for (int i = 0; i < 4; i++) begin
            nx(); bus_rdy = 1'b1; #1;
            chk(bus_lock == 1'b1, "R9", "lock during replay", bus_lock, 1);
        end
        chk(core_done == 1'b1, "R9", "end of locked sequence", core_done, 1);
        nx(); bus_rdy = 1'b0; req_lock = 1'b0; req_lock_end = 1'b0; #1;
        chk(bus_lock == 1'b0, "R9", "lock dropped", bus_lock, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not end actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule